// File: doc/BRIEF.md
# Monotonic Data-Flash Protection Register

This block holds the protection setting for a data-flash array. One enable bit and one size field together select which sectors are closed to program and erase. Right after reset the register sits in its most protective value and waits for a configuration byte. That byte is read from nonvolatile storage during the reset sequence. Its arrival, with or without an uncorrectable-error flag, sets the register exactly once.

After that load, software may write the register through a simple write strobe. Every write is filtered one field at a time, and only the parts that tighten protection take effect. The open bit can only fall, and the size field can only grow. The only way to loosen protection is to reset again with a different stored byte. A combinational query port takes a sector index and reports whether that sector is currently protected.

Top module: `dfl_prot_reg`

## Requirements
- R1: The read value places the open bit at bit 7 and the size field at bits 3:0, and bits 6:4 always read as zero.
- R2: `q_protected` is 1 exactly when the open bit is 0 and `q_sector` is less than or equal to the size field. While the open bit is 1, every sector reads unprotected.
- R3: A write can change the open bit from 1 to 0. A write with bit 7 = 1 never changes an open bit of 0 back to 1.
- R4: A write loads bits 3:0 into the size field only when that value is strictly greater than the current size. Otherwise the size field is left unchanged.
- R5: The open-bit rule and the size rule act independently within a single write, so one field may change while the other stays unchanged.
- R6: A configuration load with no error flag copies bit 7 and bits 3:0 of `cfg_byte` into the register and discards bits 6:4.
- R7: A configuration load with `cfg_dbl_err` = 1 forces the register to 0x0F, which is open = 0 and size = 15.
- R8: Out of reset the register reads 0x0F and `load_done` is 0. Writes have no effect until a load has been accepted, including a write in the same cycle as the load.
- R9: Only the first `cfg_valid` after reset is taken. Any later pulse is ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration byte is present on `cfg_byte` |
| cfg_byte | input | 8 | Protection byte read from nonvolatile storage |
| cfg_dbl_err | input | 1 | Uncorrectable error flag for `cfg_byte` |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| rd_data | output | 8 | Active protection value |
| load_done | output | 1 | The reset load has been accepted |
| q_sector | input | SECT_W | Sector index to query |
| q_protected | output | 1 | The queried sector is protected |

## Verification
Directed writes try each combination of the two fields: loosen the open bit only, shrink the size only, write an equal size, tighten one field while loosening the other, and tighten both. These cases show whether the filter works per field or accepts or rejects the whole write. Configuration loads are tried with clean bytes whose reserved bits are set, with the error flag set, with a write in the same cycle, and with a second load pulse, which separates the error override from the one-shot capture. Random writes and queries then check, after every write, the read value and the protection of each sector against a model in the bench. This also covers the edge where the size equals the queried index.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int SZ_W     = 4;
  localparam int BYTE_W   = 8;
  localparam int OPEN_POS = 7;
  localparam logic [SZ_W-1:0] SZ_MAX = '1;

  // open bit may only fall: result is 1 only when both are 1
  function automatic logic tighten_open(input logic cur, input logic req);
    return cur & req;
  endfunction

  // size may only grow strictly
  function automatic logic [SZ_W-1:0] tighten_size(input logic [SZ_W-1:0] cur,
                                                   input logic [SZ_W-1:0] req);
    return (req > cur) ? req : cur;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_view(input logic open_b,
                                                  input logic [SZ_W-1:0] size);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[OPEN_POS] = open_b;
    v[SZ_W-1:0] = size;
    return v;
  endfunction
endpackage

// File: rtl/fprot_loader.sv
module fprot_loader
  import fprot_pkg::*;
(
  input  logic            cfg_valid,
  input  logic            done_q,
  input  logic            cfg_open,
  input  logic [SZ_W-1:0] cfg_size,
  input  logic            cfg_dbl_err,
  output logic            load_fire,
  output logic            load_open,
  output logic [SZ_W-1:0] load_size
);
  assign load_fire = cfg_valid & ~done_q;

  always_comb begin
    if (cfg_dbl_err) begin
      load_open = 1'b0;
      load_size = SZ_MAX;
    end else begin
      load_open = cfg_open;
      load_size = cfg_size;
    end
  end
endmodule

// File: rtl/fprot_wfilter.sv
module fprot_wfilter
  import fprot_pkg::*;
(
  input  logic            wr_en,
  input  logic            done_q,
  input  logic            load_fire,
  input  logic            cur_open,
  input  logic [SZ_W-1:0] cur_size,
  input  logic            req_open,
  input  logic [SZ_W-1:0] req_size,
  output logic            wr_take,
  output logic            nxt_open,
  output logic [SZ_W-1:0] nxt_size
);
  assign wr_take  = wr_en & done_q & ~load_fire;
  assign nxt_open = tighten_open(cur_open, req_open);
  assign nxt_size = tighten_size(cur_size, req_size);
endmodule

// File: rtl/fprot_query.sv
module fprot_query
  import fprot_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic              open_q,
  input  logic [SZ_W-1:0]   size_q,
  input  logic [SECT_W-1:0] sector,
  output logic              hit
);
  assign hit = ~open_q & (int'(sector) <= int'(size_q));
endmodule

// File: rtl/dfl_prot_reg.sv
module dfl_prot_reg
  import fprot_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [7:0]        cfg_byte,
  input  logic              cfg_dbl_err,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              load_done,
  input  logic [SECT_W-1:0] q_sector,
  output logic              q_protected
);
  logic            open_q;
  logic [SZ_W-1:0] size_q;
  logic            done_q;

  logic            load_fire;
  logic            load_open;
  logic [SZ_W-1:0] load_size;
  logic            wr_take;
  logic            nxt_open;
  logic [SZ_W-1:0] nxt_size;

  fprot_loader u_load (
    .cfg_valid   (cfg_valid),
    .done_q      (done_q),
    .cfg_open    (cfg_byte[OPEN_POS]),
    .cfg_size    (cfg_byte[SZ_W-1:0]),
    .cfg_dbl_err (cfg_dbl_err),
    .load_fire   (load_fire),
    .load_open   (load_open),
    .load_size   (load_size)
  );

  fprot_wfilter u_wf (
    .wr_en     (wr_en),
    .done_q    (done_q),
    .load_fire (load_fire),
    .cur_open  (open_q),
    .cur_size  (size_q),
    .req_open  (wr_data[OPEN_POS]),
    .req_size  (wr_data[SZ_W-1:0]),
    .wr_take   (wr_take),
    .nxt_open  (nxt_open),
    .nxt_size  (nxt_size)
  );

  fprot_query #(.SECT_W(SECT_W)) u_q (
    .open_q (open_q),
    .size_q (size_q),
    .sector (q_sector),
    .hit    (q_protected)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      size_q <= SZ_MAX;
      done_q <= 1'b0;
    end else if (load_fire) begin
      open_q <= load_open;
      size_q <= load_size;
      done_q <= 1'b1;
    end else if (wr_take) begin
      open_q <= nxt_open;
      size_q <= nxt_size;
    end
  end

  assign rd_data   = pack_view(open_q, size_q);
  assign load_done = done_q;
endmodule

// File: rtl/dfl_prot_chk.sv
module dfl_prot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_fire,
  input logic       cfg_dbl_err,
  input logic       wr_take,
  input logic       wr_en,
  input logic       load_done,
  input logic [7:0] rd_data,
  input logic       q_protected
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000); // R1

  AST_QUERY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    q_protected |-> !rd_data[7]); // R2

  AST_OPEN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !rd_data[7]) |=> !rd_data[7]); // R3

  AST_SIZE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> rd_data[3:0] >= $past(rd_data[3:0])); // R4

  AST_DBL_ERR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && cfg_dbl_err) |=> rd_data == 8'h0F); // R7

  AST_EARLY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_done && !load_fire && wr_en) |=> $stable(rd_data)); // R8

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !load_fire); // R9

  AST_TAKE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> load_done); // R8
endmodule

bind dfl_prot_reg dfl_prot_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_fire   (load_fire),
  .cfg_dbl_err (cfg_dbl_err),
  .wr_take     (wr_take),
  .wr_en       (wr_en),
  .load_done   (load_done),
  .rd_data     (rd_data),
  .q_protected (q_protected)
);

// File: tb/sim_dfl_prot_reg.sv
`timescale 1ns/1ps
module sim_dfl_prot_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [7:0] cfg_byte = '0;
  logic       cfg_dbl_err = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       load_done;
  logic [3:0] q_sector = '0;
  logic       q_protected;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  logic       m_open;
  logic [3:0] m_size;

  always #4 clk = ~clk;

  dfl_prot_reg #(.SECT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
    .cfg_dbl_err(cfg_dbl_err), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .load_done(load_done), .q_sector(q_sector),
    .q_protected(q_protected)
  );

  function automatic logic [7:0] view(input logic o, input logic [3:0] s);
    return {o, 3'b000, s};
  endfunction

  function automatic logic prot_of(input logic o, input logic [3:0] s, input logic [3:0] k);
    if (o) return 1'b0;
    return (k <= s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_open = 1'b0; m_size = 4'hF;
    @(negedge clk);
    check("R8 reset value", rd_data, 8'h0F);
    check("R8 load_done low", load_done, 1'b0);
  endtask

  task automatic do_load(input logic [7:0] b, input logic err);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_byte = b; cfg_dbl_err = err;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_dbl_err = 1'b0;
    if (err) begin m_open = 1'b0; m_size = 4'hF; end
    else begin m_open = b[7]; m_size = b[3:0]; end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!d[7]) m_open = 1'b0;
    if (d[3:0] > m_size) m_size = d[3:0];
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 16; k++) begin
      q_sector = 4'(k);
      #1;
      check(req, q_protected, prot_of(m_open, m_size, 4'(k)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R8: write before load has no effect
    do_write(8'h00);
    m_open = 1'b0; m_size = 4'hF;
    check("R8 early write ignored", rd_data, 8'h0F);

    // R6: clean load with reserved bits set
    do_load(8'hF3, 1'b0);
    check("R6 clean load", rd_data, 8'h83);
    check("R1 reserved zero", rd_data[6:4], 3'b000);
    check("R8 load_done high", load_done, 1'b1);
    sweep("R2 open means none protected");

    // R5: close open bit and grow size together
    do_write(8'h05);
    check("R5 both fields", rd_data, 8'h05);
    // R3: try to reopen, smaller size
    do_write(8'h83);
    check("R3 reopen blocked", rd_data, 8'h05);
    // R4: equal size does nothing
    do_write(8'h05);
    check("R4 equal size kept", rd_data, 8'h05);
    // R5: loosen open, grow size -> size only
    do_write(8'h86);
    check("R5 size only", rd_data, 8'h06);
    sweep("R2 sector limit");

    // R9: second load ignored
    do_load(8'h80, 1'b0);
    m_open = 1'b0; m_size = 4'h6;
    check("R9 second load ignored", rd_data, 8'h06);

    // R7: double-bit error
    do_reset();
    do_load(8'h80, 1'b1);
    check("R7 dbl err forced", rd_data, 8'h0F);
    sweep("R2 full protection");

    // R3: open only in a write; size shrink ignored
    do_reset();
    do_load(8'h88, 1'b0);
    do_write(8'h02);
    check("R3 open clear only", rd_data, 8'h08);

    // R8: write in the same cycle as the load is dropped
    do_reset();
    @(negedge clk);
    cfg_valid = 1'b1; cfg_byte = 8'h81; cfg_dbl_err = 1'b0;
    wr_en = 1'b1; wr_data = 8'h07;
    @(negedge clk);
    cfg_valid = 1'b0; wr_en = 1'b0;
    m_open = 1'b1; m_size = 4'h1;
    check("R8 same-cycle write dropped", rd_data, 8'h81);

    // random rounds (R3 R4 R5 R2)
    for (int r = 0; r < 6; r++) begin
      logic [7:0] b;
      do_reset();
      b = 8'($urandom);
      b[7] = 1'b1;
      b[3:0] = 4'($urandom_range(0, 4));
      do_load(b, 1'b0);
      check("R6 random load", rd_data, view(m_open, m_size));
      for (int w = 0; w < 20; w++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (($urandom % 4) != 0) d[7] = 1'b1;
        do_write(d);
        check("R4 R3 random write", rd_data, view(m_open, m_size));
        q_sector = 4'($urandom);
        #1;
        check("R2 random query", q_protected, prot_of(m_open, m_size, q_sector));
      end
    end

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule